// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory read or write burst. When a read or write command is accepted, the block captures the start column, the burst length (1, 2, 4 or 8), the wrap order (sequential or interleaved) and the single-write setting. It then steps through the beats of the burst, one per clock, and presents the column for each beat along with a beat-valid flag and the direction of the access.

Both wrap orders stay inside the block of columns that is aligned to the burst length. Column bits above that block never change during a burst. On the final beat, the block raises a one-cycle done pulse that a downstream controller can use to start an auto-precharge. A later read or write command restarts the sequence from its own start column. A precharge command cuts the burst short and produces no done pulse.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after reset is released with no command issued, `beat_valid`, `burst_done` and `beat_write` are 0.
- R2: With `ilv_order`=0 (sequential), beat k presents the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. All higher bits are unchanged.
- R3: With `ilv_order`=1 (interleave), beat k presents the start column with its low log2(BL) bits XORed with k. All higher bits are unchanged.
- R4: A read (`cmd_op`=1) or write (`cmd_op`=2) command sampled at a clock edge makes beat 0 visible in the following cycle, at exactly the start column. With no further command, `beat_valid` stays high for exactly BL consecutive cycles.
- R5: `bl_sel` sets the burst length: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. All mode inputs are captured together with the command.
- R6: When `wr_single`=1, a write command produces exactly one beat, at the start column. A read command issued with the same setting still produces a full burst.
- R7: `burst_done` is high only on the last beat of a burst that runs to completion, and `beat_valid` is 0 in the cycle after that beat.
- R8: A read or write command that arrives during a burst abandons the old burst without a done pulse. The next cycle shows beat 0 of the new burst, using the new command's start column and modes.
- R9: A precharge command (`cmd_op`=3) during a burst makes `beat_valid` and `burst_done` 0 from the next cycle onward. `cmd_op`=0 is a no-op.
- R10: `beat_write` is 1 on the beats of a write burst and 0 on the beats of a read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Command: 0 none, 1 read, 2 write, 3 precharge |
| start_col | input | COL_W | Start column given with a read or write |
| bl_sel | input | 2 | Burst length select: 0→1, 1→2, 2→4, 3→8 |
| ilv_order | input | 1 | 0 sequential order, 1 interleaved order |
| wr_single | input | 1 | 1: writes access a single column |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| beat_write | output | 1 | The current beat belongs to a write |
| burst_done | output | 1 | Final beat of a completed burst |

## Verification
A beat counter in the wrong state shows up at once on `col_addr`: a sequential burst that fails to wrap, or an interleaved burst with the wrong XOR pattern, presents a wrong column within one cycle of the error. A wrong captured length shows up either as a `burst_done` pulse on the wrong beat or as `beat_valid` staying high one cycle too long or too short. A missed restart or a missed precharge is visible in the very next cycle, as an old column or a stray valid beat. The directed tests start bursts at offsets that are not aligned, so every wrap point is exercised, and they issue interrupting commands in the middle of bursts.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_PRE   = 2'd3
  } burst_op_e;

  // log2 of the largest supported burst length
  localparam int unsigned BEAT_LOG_MAX = 3;

  function automatic logic [BEAT_LOG_MAX-1:0] len_to_mask(input logic [1:0] sel);
    logic [BEAT_LOG_MAX-1:0] m;
    m = '0;
    for (int i = 0; i < BEAT_LOG_MAX; i++) begin
      if (i < int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
#(
  parameter int unsigned CNT_W = BEAT_LOG_MAX
) (
  input  logic [1:0]       cmd_op,
  input  logic [1:0]       bl_sel,
  input  logic             wr_single,
  output logic             start_go,
  output logic             stop_go,
  output logic             start_is_wr,
  output logic [CNT_W-1:0] start_mask
);

  burst_op_e op;

  always_comb begin
    op          = burst_op_e'(cmd_op);
    start_go    = (op == OP_READ) || (op == OP_WRITE);
    start_is_wr = (op == OP_WRITE);
    stop_go     = (op == OP_PRE);
    if (start_is_wr && wr_single) begin
      start_mask = '0;
    end else begin
      start_mask = len_to_mask(bl_sel);
    end
  end

endmodule

// File: rtl/burst_beat_track.sv
module burst_beat_track #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic             stop_go,
  input  logic             start_is_wr,
  input  logic [CNT_W-1:0] start_mask,
  input  logic [COL_W-1:0] start_col,
  input  logic             ilv_in,
  output logic             active,
  output logic [CNT_W-1:0] beat_cnt,
  output logic [CNT_W-1:0] len_mask,
  output logic [COL_W-1:0] base_col,
  output logic             is_wr,
  output logic             ilv_mode
);

  logic             active_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cap_en;
  logic             last_beat;

  always_comb begin
    cap_en    = start_go;
    last_beat = (beat_cnt == len_mask);
    active_d  = active;
    cnt_d     = beat_cnt;
    if (start_go) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (stop_go) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active) begin
      if (last_beat) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = beat_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat_cnt <= '0;
    end else begin
      active   <= active_d;
      beat_cnt <= cnt_d;
    end
  end

  // captured burst parameters, loaded only when a burst starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_mask <= '0;
      base_col <= '0;
      is_wr    <= 1'b0;
      ilv_mode <= 1'b0;
    end else if (cap_en) begin
      len_mask <= start_mask;
      base_col <= start_col;
      is_wr    <= start_is_wr;
      ilv_mode <= ilv_in;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned CNT_W = 3
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [CNT_W-1:0] beat_cnt,
  input  logic [CNT_W-1:0] len_mask,
  input  logic             ilv_mode,
  output logic [COL_W-1:0] col_addr
);

  logic [CNT_W-1:0] seq_sum;

  assign seq_sum = base_col[CNT_W-1:0] + beat_cnt;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < CNT_W) begin : g_low
      logic seq_bit;
      logic ilv_bit;
      assign seq_bit     = len_mask[i] ? seq_sum[i] : base_col[i];
      assign ilv_bit     = base_col[i] ^ (beat_cnt[i] & len_mask[i]);
      assign col_addr[i] = ilv_mode ? ilv_bit : seq_bit;
    end else begin : g_high
      assign col_addr[i] = base_col[i];
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_sel,
  input  logic             ilv_order,
  input  logic             wr_single,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_write,
  output logic             burst_done
);

  localparam int unsigned CNT_W = BEAT_LOG_MAX;

  logic             start_go;
  logic             stop_go;
  logic             start_is_wr;
  logic [CNT_W-1:0] start_mask;
  logic             active;
  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] len_mask;
  logic [COL_W-1:0] base_col;
  logic             is_wr;
  logic             ilv_mode;

  burst_cmd_decode #(.CNT_W(CNT_W)) dec_i (
    .cmd_op      (cmd_op),
    .bl_sel      (bl_sel),
    .wr_single   (wr_single),
    .start_go    (start_go),
    .stop_go     (stop_go),
    .start_is_wr (start_is_wr),
    .start_mask  (start_mask)
  );

  burst_beat_track #(.COL_W(COL_W), .CNT_W(CNT_W)) trk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_go    (start_go),
    .stop_go     (stop_go),
    .start_is_wr (start_is_wr),
    .start_mask  (start_mask),
    .start_col   (start_col),
    .ilv_in      (ilv_order),
    .active      (active),
    .beat_cnt    (beat_cnt),
    .len_mask    (len_mask),
    .base_col    (base_col),
    .is_wr       (is_wr),
    .ilv_mode    (ilv_mode)
  );

  burst_addr_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) agen_i (
    .base_col (base_col),
    .beat_cnt (beat_cnt),
    .len_mask (len_mask),
    .ilv_mode (ilv_mode),
    .col_addr (col_addr)
  );

  assign beat_valid = active;
  assign beat_write = active & is_wr;
  assign burst_done = active & (beat_cnt == len_mask);

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_op,
  input logic [COL_W-1:0] start_col,
  input logic             wr_single,
  input logic [COL_W-1:0] col_addr,
  input logic             beat_valid,
  input logic             beat_write,
  input logic             burst_done
);

  AST_IDLE_IN_RESET: assert property (@(posedge clk) !rst_n |-> !beat_valid && !burst_done); // R1
  AST_START_AT_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1 || cmd_op == 2'd2) |=> beat_valid && col_addr == $past(start_col)); // R4
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !burst_done && cmd_op == 2'd0) |=>
      beat_valid && col_addr[COL_W-1:CNT_W] == $past(col_addr[COL_W-1:CNT_W])); // R2
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd2 && wr_single) |=> burst_done && beat_write); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && cmd_op == 2'd0) |=> !beat_valid); // R7
  AST_DONE_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_valid); // R7
  AST_PRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd3) |=> !beat_valid && !burst_done); // R9
  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1) |=> !beat_write); // R10

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_op     (cmd_op),
  .start_col  (start_col),
  .wr_single  (wr_single),
  .col_addr   (col_addr),
  .beat_valid (beat_valid),
  .beat_write (beat_write),
  .burst_done (burst_done)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

  localparam int COL_W = 10;

  logic             clk;
  logic             rst_n;
  logic [1:0]       cmd_op;
  logic [COL_W-1:0] start_col;
  logic [1:0]       bl_sel;
  logic             ilv_order;
  logic             wr_single;
  logic [COL_W-1:0] col_addr;
  logic             beat_valid;
  logic             beat_write;
  logic             burst_done;

  int checks;
  int failures;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_op     (cmd_op),
    .start_col  (start_col),
    .bl_sel     (bl_sel),
    .ilv_order  (ilv_order),
    .wr_single  (wr_single),
    .col_addr   (col_addr),
    .beat_valid (beat_valid),
    .beat_write (beat_write),
    .burst_done (burst_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int col, input int bl, input bit ilv, input int k);
    int lowm;
    lowm = bl - 1;
    if (ilv) return col ^ k;
    return (col & ~lowm) | ((col + k) % bl);
  endfunction

  // apply a command at a negedge; returns at next negedge with beat 0 visible
  task automatic issue(input int op, input int col, input int sel, input bit ilv, input bit sw);
    cmd_op    = 2'(op);
    start_col = COL_W'(col);
    bl_sel    = 2'(sel);
    ilv_order = ilv;
    wr_single = sw;
    @(negedge clk);
    cmd_op    = 2'd0;
    bl_sel    = 2'd0;
    ilv_order = 1'b0;
    wr_single = 1'b0;
    start_col = '0;
  endtask

  // check beats first..len-1 of a burst, then the idle cycle after it
  task automatic follow(input string req, input int col, input int len, input bit ilv,
                        input bit wr, input int first);
    for (int k = first; k < len; k++) begin
      chk({req, " valid"}, int'(beat_valid), 1);
      chk({req, " col"}, int'(col_addr), exp_col(col, len, ilv, k));
      chk({req, " R7 done"}, int'(burst_done), (k == len - 1) ? 1 : 0);
      chk({req, " R10 write"}, int'(beat_write), int'(wr));
      @(negedge clk);
    end
    chk({req, " R4 valid after end"}, int'(beat_valid), 0);
    chk({req, " R7 done after end"}, int'(burst_done), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cmd_op = 2'd0; start_col = '0; bl_sel = 2'd0; ilv_order = 1'b0; wr_single = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(beat_valid), 0);
    chk("R1 done in reset", int'(burst_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid idle", int'(beat_valid), 0);
    chk("R1 write idle", int'(beat_write), 0);
  endtask

  task automatic t_seq;
    issue(1, 'h016, 2, 1'b0, 1'b0);
    follow("R2 seq bl4", 'h016, 4, 1'b0, 1'b0, 0);
    issue(2, 'h3FB, 3, 1'b0, 1'b0);
    follow("R2 seq bl8 wr", 'h3FB, 8, 1'b0, 1'b1, 0);
  endtask

  task automatic t_ilv;
    issue(1, 'h02D, 3, 1'b1, 1'b0);
    follow("R3 ilv bl8", 'h02D, 8, 1'b1, 1'b0, 0);
    issue(2, 'h103, 1, 1'b1, 1'b0);
    follow("R3 ilv bl2", 'h103, 2, 1'b1, 1'b1, 0);
  endtask

  task automatic t_lengths;
    issue(1, 'h0A5, 0, 1'b0, 1'b0);
    follow("R5 bl1", 'h0A5, 1, 1'b0, 1'b0, 0);
    issue(1, 'h0A5, 1, 1'b0, 1'b0);
    follow("R5 bl2 R4", 'h0A5, 2, 1'b0, 1'b0, 0);
  endtask

  task automatic t_single;
    issue(2, 'h277, 3, 1'b0, 1'b1);
    follow("R6 single wr", 'h277, 1, 1'b0, 1'b1, 0);
    issue(1, 'h277, 3, 1'b0, 1'b1);
    follow("R6 read bursts", 'h277, 8, 1'b0, 1'b0, 0);
  endtask

  task automatic t_restart;
    issue(1, 'h040, 3, 1'b0, 1'b0);
    chk("R8 old beat0", int'(col_addr), 'h040);
    @(negedge clk);
    chk("R8 old beat1", int'(col_addr), 'h041);
    chk("R8 old no done", int'(burst_done), 0);
    issue(2, 'h083, 2, 1'b1, 1'b0);
    follow("R8 restart", 'h083, 4, 1'b1, 1'b1, 0);
  endtask

  task automatic t_precharge;
    issue(2, 'h150, 3, 1'b1, 1'b0);
    chk("R9 beat0", int'(col_addr), 'h150);
    @(negedge clk);
    chk("R9 beat1", int'(col_addr), 'h151);
    issue(3, 'h000, 0, 1'b0, 1'b0);
    chk("R9 stopped valid", int'(beat_valid), 0);
    chk("R9 stopped done", int'(burst_done), 0);
    repeat (3) @(negedge clk);
    chk("R9 stays idle", int'(beat_valid), 0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_lengths();
    t_single();
    t_restart();
    t_precharge();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule